// File: doc/BRIEF.md
# Command-Data Packet Unpacker

This block sits behind a linear command-data buffer that a host fills with programmed writes or with a DMA engine. The buffer holds self-describing packets. Each packet is one header word followed by its data words in the slots that come right after it. The block walks the buffer with its own read pointer and expands every packet into a sequence of internal register writes. Each write goes out on a valid/ready port.

Host writes may arrive in any order. The block therefore keeps a written flag for each buffer slot. It never consumes a slot whose flag is clear, even when slots beyond it are already filled. Consuming a slot clears its flag, so the host can reuse the slot once it has wrapped its own write pointer back to the top. A header tells the block to follow the host back to slot 0 once that packet is done.

Header layout: data-word count in bits 31:27, bit 26 reserved, bit 25 set to hold the address fixed, bit 24 set to wrap, and the 24-bit start address in bits 23:0.

Top module: `cdbu_unpacker`

## Requirements
- R1: A header whose bits 31:27 hold N (1 to 31) produces exactly N internal writes, one per data word.
- R2: With header bit 25 clear, the first write goes to the address in bits 23:0 and each later write goes to the previous address plus one, modulo 2^24.
- R3: With header bit 25 set, every write of the packet goes to the address in bits 23:0.
- R4: With header bit 24 set, the header that follows the packet is read from slot 0 rather than the next slot.
- R5: The data words are taken from the slots directly after the header, in ascending slot order, and each one appears unchanged as the data of one write.
- R6: The block stalls while the next slot to be consumed has not been written, even if later slots have been written.
- R7: A consumed slot counts as unwritten until the host writes it again, so a stale slot is never parsed a second time.
- R8: A header with count 0 produces no write; it only applies its wrap flag, or else moves on to the next slot.
- R9: Header bit 26 has no effect on the writes produced.
- R10: While reg_valid is high and reg_ready is low, reg_valid stays high and reg_addr and reg_data stay unchanged.
- R11: After reset, reg_valid is low and the block waits for a header in slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe into the buffer |
| host_idx | input | $clog2(DEPTH) | Buffer slot being written |
| host_data | input | 32 | Word written into the slot |
| reg_valid | output | 1 | An internal register write is offered |
| reg_ready | input | 1 | The internal register fabric accepts the write |
| reg_addr | output | 24 | Internal register address |
| reg_data | output | 32 | Internal register data |

## Verification
On every cycle the assertions check three things. Nothing is consumed from an unwritten slot. A consumed slot's flag is cleared unless the host rewrites that slot in the same cycle. An offered write stays unchanged while it is back-pressured. They also check how a count-zero header moves the read pointer. Address sequencing, data order, the effect of the reserved bit, the wrap to slot 0 after a full packet, and the refusal to re-read stale slots after a wrap are all judged end to end. The bench's scenarios do this by comparing each accepted write against a packet model while slot writes arrive shuffled and ready is throttled at random.

// File: rtl/cdbu_pkg.sv
package cdbu_pkg;
  localparam int WORD_W = 32;
  localparam int IADDR_W = 24;
  localparam int CNT_W = 5;

  typedef struct packed {
    logic [CNT_W-1:0]   cnt;
    logic               rsv;
    logic               fixed;
    logic               wrap;
    logic [IADDR_W-1:0] addr;
  } cdbu_hdr_t;
endpackage

// File: rtl/cdbu_slots.sv
module cdbu_slots #(
  parameter int DEPTH = 64,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IW-1:0]    rd_idx,
  input  logic             clr_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_ok,
  output logic [DEPTH-1:0] full_vec
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] full_q, full_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    full_d = full_q;
    if (clr_en) full_d[rd_idx] = 1'b0;
    if (wr_en)  full_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  assign rd_data  = mem[rd_idx];
  assign rd_ok    = full_q[rd_idx];
  assign full_vec = full_q;
endmodule

// File: rtl/cdbu_parse.sv
module cdbu_parse
  import cdbu_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  slot_data,
  input  logic               slot_ok,
  input  logic               out_ready,
  output logic [IW-1:0]      rd_ptr,
  output logic               consume,
  output logic               hdr_phase,
  output logic               out_valid,
  output logic [IADDR_W-1:0] out_addr,
  output logic [WORD_W-1:0]  out_data
);
  cdbu_hdr_t hdr;
  logic               in_pkt_q, in_pkt_d;
  logic [IW-1:0]      ptr_q, ptr_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [IADDR_W-1:0] addr_q, addr_d;
  logic               step_q, step_d;
  logic               wrap_q, wrap_d;
  logic               ov_q, ov_d;
  logic [IADDR_W-1:0] oa_q, oa_d;
  logic [WORD_W-1:0]  od_q, od_d;
  logic               out_free, take;

  assign hdr      = cdbu_hdr_t'(slot_data);
  assign out_free = !ov_q || out_ready;
  assign take     = slot_ok && (!in_pkt_q || out_free);

  always_comb begin
    in_pkt_d = in_pkt_q;
    ptr_d    = ptr_q;
    left_d   = left_q;
    addr_d   = addr_q;
    step_d   = step_q;
    wrap_d   = wrap_q;
    ov_d     = ov_q && !out_ready;
    oa_d     = oa_q;
    od_d     = od_q;
    if (take) begin
      if (!in_pkt_q) begin
        if (hdr.cnt == '0) begin
          ptr_d = hdr.wrap ? '0 : ptr_q + IW'(1);
        end else begin
          in_pkt_d = 1'b1;
          left_d   = hdr.cnt;
          addr_d   = hdr.addr;
          step_d   = !hdr.fixed;
          wrap_d   = hdr.wrap;
          ptr_d    = ptr_q + IW'(1);
        end
      end else begin
        ov_d   = 1'b1;
        oa_d   = addr_q;
        od_d   = slot_data;
        addr_d = addr_q + {{(IADDR_W-1){1'b0}}, step_q};
        left_d = left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          in_pkt_d = 1'b0;
          ptr_d    = wrap_q ? '0 : ptr_q + IW'(1);
        end else begin
          ptr_d = ptr_q + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      ptr_q    <= '0;
      left_q   <= '0;
      addr_q   <= '0;
      step_q   <= 1'b0;
      wrap_q   <= 1'b0;
      ov_q     <= 1'b0;
      oa_q     <= '0;
      od_q     <= '0;
    end else begin
      in_pkt_q <= in_pkt_d;
      ptr_q    <= ptr_d;
      left_q   <= left_d;
      addr_q   <= addr_d;
      step_q   <= step_d;
      wrap_q   <= wrap_d;
      ov_q     <= ov_d;
      oa_q     <= oa_d;
      od_q     <= od_d;
    end
  end

  assign rd_ptr    = ptr_q;
  assign consume   = take;
  assign hdr_phase = !in_pkt_q;
  assign out_valid = ov_q;
  assign out_addr  = oa_q;
  assign out_data  = od_q;
endmodule

// File: rtl/cdbu_unpacker.sv
module cdbu_unpacker
  import cdbu_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [IW-1:0]      host_idx,
  input  logic [WORD_W-1:0]  host_data,
  output logic               reg_valid,
  input  logic               reg_ready,
  output logic [IADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0]  reg_data
);
  logic [WORD_W-1:0] slot_data;
  logic              slot_ok;
  logic [IW-1:0]     rd_ptr;
  logic              consume;
  logic              hdr_phase;
  logic [DEPTH-1:0]  full_vec;

  cdbu_slots #(.DEPTH(DEPTH), .DW(WORD_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_we),
    .wr_idx   (host_idx),
    .wr_data  (host_data),
    .rd_idx   (rd_ptr),
    .clr_en   (consume),
    .rd_data  (slot_data),
    .rd_ok    (slot_ok),
    .full_vec (full_vec)
  );

  cdbu_parse #(.IW(IW)) u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_data (slot_data),
    .slot_ok   (slot_ok),
    .out_ready (reg_ready),
    .rd_ptr    (rd_ptr),
    .consume   (consume),
    .hdr_phase (hdr_phase),
    .out_valid (reg_valid),
    .out_addr  (reg_addr),
    .out_data  (reg_data)
  );
endmodule

// File: rtl/cdbu_checks.sv
module cdbu_checks #(
  parameter int DEPTH = 64,
  parameter int IW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic [IW-1:0]    host_idx,
  input logic             reg_valid,
  input logic             reg_ready,
  input logic [23:0]      reg_addr,
  input logic [31:0]      reg_data,
  input logic [31:0]      slot_data,
  input logic             slot_ok,
  input logic [IW-1:0]    rd_ptr,
  input logic             consume,
  input logic             hdr_phase,
  input logic [DEPTH-1:0] full_vec
);
  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_ok |-> !consume);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !(host_we && host_idx == rd_ptr)) |=> !full_vec[$past(rd_ptr)]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) && $stable(reg_data)));

  p_zero_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && hdr_phase && slot_data[31:27] == 5'd0 && slot_data[24]) |=> rd_ptr == '0);

  p_zero_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && hdr_phase && slot_data[31:27] == 5'd0 && !slot_data[24])
      |=> rd_ptr == $past(rd_ptr) + IW'(1));

  p_hdr_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && hdr_phase && !reg_valid) |=> !reg_valid);
endmodule

bind cdbu_unpacker cdbu_checks #(.DEPTH(DEPTH), .IW(IW)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .host_idx  (host_idx),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .reg_addr  (reg_addr),
  .reg_data  (reg_data),
  .slot_data (slot_data),
  .slot_ok   (slot_ok),
  .rd_ptr    (rd_ptr),
  .consume   (consume),
  .hdr_phase (hdr_phase),
  .full_vec  (full_vec)
);

// File: tb/cdbu_unpacker_bench.sv
`timescale 1ns/1ps
module cdbu_unpacker_bench;
  localparam int DEPTH = 64;
  localparam int IW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [IW-1:0] host_idx = '0;
  logic [31:0]   host_data = '0;
  logic          reg_valid;
  logic          reg_ready = 1'b0;
  logic [23:0]   reg_addr;
  logic [31:0]   reg_data;

  int checks = 0;
  int failures = 0;
  int wp = 0;
  bit done = 1'b0;
  bit throttle = 1'b0;
  logic [55:0] exp_q[$];

  always #4 clk = ~clk;

  cdbu_unpacker #(.DEPTH(DEPTH)) u_cdbu_unpacker (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
    .host_data(host_data), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_addr(reg_addr), .reg_data(reg_data)
  );

  function automatic logic [31:0] mk_hdr(int cnt, bit fixed, bit wrap, bit rsv, logic [23:0] a);
    return {cnt[4:0], rsv, fixed, wrap, a};
  endfunction

  function automatic logic [23:0] exp_addr(logic [23:0] a, bit fixed, int i);
    return fixed ? a : a + 24'(i);
  endfunction

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      reg_ready = throttle ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // monitor: compares accepted writes (R1 R2 R3 R5 R7 R9) and hold (R10)
  logic        pend = 1'b0;
  logic [23:0] pend_a;
  logic [31:0] pend_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        checks++;
        if (!(reg_valid && reg_addr == pend_a && reg_data == pend_d)) begin
          failures++;
          $display("FAIL R10 held write changed: actual v=%0b %h/%h expected v=1 %h/%h",
                   reg_valid, reg_addr, reg_data, pend_a, pend_d);
        end
      end
      pend   = reg_valid && !reg_ready;
      pend_a = reg_addr;
      pend_d = reg_data;
      if (reg_valid && reg_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R7 unexpected write: actual %h/%h expected none", reg_addr, reg_data);
        end else begin
          logic [55:0] e;
          e = exp_q.pop_front();
          if ({reg_addr, reg_data} != e) begin
            failures++;
            $display("FAIL R5 write mismatch: actual %h/%h expected %h/%h",
                     reg_addr, reg_data, e[55:32], e[31:0]);
          end
        end
      end
    end
  end

  task automatic host_write(int idx, logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_idx = IW'(idx); host_data = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0 || reg_valid) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // build packet at wp, write header last when stall_hdr set, else in shuffled order
  task automatic send_pkt(int cnt, bit fixed, bit wrap, bit rsv, logic [23:0] a,
                          bit shuffle, bit stall_hdr);
    logic [31:0] w [34];
    int order [34];
    int n = cnt + 1;
    w[0] = mk_hdr(cnt, fixed, wrap, rsv, a);
    for (int i = 1; i < n; i++) begin
      w[i] = $urandom;
      exp_q.push_back({exp_addr(a, fixed, i - 1), w[i]});
    end
    for (int i = 0; i < n; i++) order[i] = i;
    if (shuffle) begin
      for (int i = n - 1; i > 0; i--) begin
        int j = $urandom % (i + 1);
        int t = order[i]; order[i] = order[j]; order[j] = t;
      end
    end
    if (stall_hdr) begin
      for (int i = 1; i < n; i++) host_write(wp + i, w[i]);
      repeat (20) @(negedge clk);
      checks++;
      if (reg_valid) begin
        failures++;
        $display("FAIL R6 write offered before header slot written: actual 1 expected 0");
      end
      host_write(wp, w[0]);
    end else begin
      for (int i = 0; i < n; i++) host_write(wp + order[i], w[order[i]]);
    end
    wp = wrap ? 0 : (wp + n) % DEPTH;
    if (wrap) wait_drain();
  endtask

  task automatic check_idle(string tag);
    repeat (25) @(negedge clk);
    checks++;
    if (reg_valid) begin
      failures++;
      $display("FAIL %s stale slot produced a write: actual 1 expected 0", tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    checks++;
    if (reg_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset valid: actual %b expected 0", reg_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (reg_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 idle after reset: actual %b expected 0", reg_valid);
    end
    // R1 R2 R5: incrementing
    send_pkt(3, 0, 0, 0, 24'h000100, 0, 0);
    // R3: fixed address
    send_pkt(4, 1, 0, 0, 24'h55AA00, 1, 0);
    // R2: address rolls over 2^24
    send_pkt(4, 0, 0, 0, 24'hFFFFFE, 1, 0);
    // R9: reserved bit set
    send_pkt(2, 0, 0, 1, 24'h000200, 0, 0);
    // R8: count zero without wrap, then a normal packet
    send_pkt(0, 0, 0, 0, 24'h123456, 0, 0);
    send_pkt(1, 1, 0, 1, 24'h000300, 0, 0);
    // R6: data written before header
    throttle = 1'b1;
    send_pkt(5, 0, 0, 0, 24'h000400, 0, 1);
    // R8 with R4: count zero wrap
    send_pkt(0, 0, 1, 0, 24'h000000, 0, 0);
    // R7: old slots at 0.. are stale, nothing must come out
    check_idle("R7");
    // R4: packet with data and wrap, then next packet at slot 0
    send_pkt(6, 0, 1, 0, 24'h000500, 1, 0);
    check_idle("R7");
    send_pkt(2, 0, 0, 0, 24'h000600, 1, 0);
    // random traffic
    for (int k = 0; k < 60; k++) begin
      int c = $urandom % 16;
      bit wr = ($urandom % 8 == 0);
      if (wp + 1 + c + 17 > DEPTH) wr = 1'b1;
      send_pkt(c, bit'($urandom % 2), wr, bit'($urandom % 2), 24'($urandom), 1, 0);
    end
    wait_drain();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 missing writes: actual %0d left expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R6 watchdog expired: actual hung expected drained");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule